// File: doc/BRIEF.md
# Quad-Core Cluster Configuration Registers

This block is the software-visible configuration window of a four-core processor cluster. It sits on a simple 32-bit register bus (address, write enable, write data, read enable, read data) and decodes a 1 KiB window of word-aligned byte offsets. Three registers hold state: a general-control word, a standby flag and a boot entry address. Every other cluster register returns a fixed value chosen so that boot software sees all cores released from reset, coherent, and with their clocks running.

The only side effect is core start-up. A write of any non-zero value to a core's reset-control register sends a one-cycle request to that core. The core is chosen by which register is written, not by the data. The request carries the stored entry address and a fixed exception level of 3. The power sequencing that follows the request belongs to logic outside this block. Offsets that exist in the map but have no function here read as zero and pulse an "unimplemented" flag. Any other offset, and any address that is not word-aligned, reads as zero and pulses an out-of-range flag.

Top module: `cpu_cluster_cfg`

## Requirements
- R1: After reset, general control reads 0x00000020, the standby flag reads 0 and the entry address reads 0. All request and flag outputs are low.
- R2: The cluster reset register (0x000) and the system reset register (0x140) always read 0x00000001. Writes to them have no effect.
- R3: For core n (n = 0..3), the reset-control register at 0x040+0x40·n reads 0x00000003. The control register at 0x044+0x40·n reads 0. The status register at 0x048+0x40·n reads 0x00000001.
- R4: The clock-gating register (0x144) always reads 0x0000010F. Writes to it have no effect.
- R5: General control (0x184), standby flag (0x1A0) and entry address (0x1A4) are full 32-bit read/write registers.
- R6: A write of non-zero data to the reset-control register of core n sets bit n of `core_start`, and only that bit, for exactly one cycle. The pulse comes in the cycle after the write. During that cycle `start_addr` holds the entry address and `start_el` reads 3.
- R7: A write of zero to a core reset-control register produces no start pulse.
- R8: `rd_data` carries the selected register in the cycle after `rd_en` is high. In every other cycle it is 0.
- R9: Offsets 0x1E4, 0x280, 0x284 and 0x288 read 0 and ignore writes. Any read or write to one of them sets `unimpl_err` for one cycle, in the cycle after the access.
- R10: Any other offset, including an unused slot inside a core's 0x40 block and any address whose two low bits are not 00, reads 0. Any access to such an address sets `range_err` for one cycle, in the cycle after the access. A write to a misaligned address changes no register.
- R11: Writes to a core's control or status register have no effect on what that register reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 10 | Byte offset within the 1 KiB window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, one cycle after `bus_re` |
| core_start | output | 4 | One-hot, single-cycle core start request |
| start_addr | output | 32 | Entry address sent with the start request |
| start_el | output | 2 | Exception level sent with the start request |
| unimpl_err | output | 1 | Pulse: an unimplemented register was accessed |
| range_err | output | 1 | Pulse: an out-of-range or misaligned address was accessed |

## Verification
The assertions assume that the bus strobes are never unknown after reset. They also assume that a core start pulse can never coincide with a change to the entry address, which follows from the bus carrying at most one write per cycle. The bench honours both assumptions. It drives a single read or a single write per access, on the falling clock edge, and holds both strobes low between accesses. Because of this, the cycle after each access shows that access alone on `rd_data`, the flags and `core_start`.

// File: rtl/cpu_cluster_cfg.sv
module cpu_cluster_cfg #(
  parameter int          NCORES  = 4,
  parameter int          ADDR_W  = 10,
  parameter int          DATA_W  = 32,
  parameter logic [31:0] GEN_RST = 32'h0000_0020,
  parameter logic [1:0]  BOOT_EL = 2'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [DATA_W-1:0] rd_data,
  output logic [NCORES-1:0] core_start,
  output logic [DATA_W-1:0] start_addr,
  output logic [1:0]        start_el,
  output logic              unimpl_err,
  output logic              range_err
);

  localparam int IDX_W    = (NCORES > 1) ? $clog2(NCORES) : 1;
  localparam int SLOT_SH  = 6;

  localparam logic [ADDR_W-1:0] A_CLU_RST  = ADDR_W'('h000);
  localparam logic [ADDR_W-1:0] A_CORE_LO  = ADDR_W'('h040);
  localparam logic [ADDR_W-1:0] A_CORE_HI  = ADDR_W'('h040 + ('h040 * NCORES));
  localparam logic [ADDR_W-1:0] A_SYS_RST  = ADDR_W'('h140);
  localparam logic [ADDR_W-1:0] A_CLK_GATE = ADDR_W'('h144);
  localparam logic [ADDR_W-1:0] A_GEN      = ADDR_W'('h184);
  localparam logic [ADDR_W-1:0] A_STBY     = ADDR_W'('h1A0);
  localparam logic [ADDR_W-1:0] A_ENTRY    = ADDR_W'('h1A4);
  localparam logic [ADDR_W-1:0] A_DBG      = ADDR_W'('h1E4);
  localparam logic [ADDR_W-1:0] A_CNT_CTL  = ADDR_W'('h280);
  localparam logic [ADDR_W-1:0] A_CNT_LO   = ADDR_W'('h284);
  localparam logic [ADDR_W-1:0] A_CNT_HI   = ADDR_W'('h288);

  localparam logic [SLOT_SH-1:0] S_RST  = SLOT_SH'('h00);
  localparam logic [SLOT_SH-1:0] S_CTRL = SLOT_SH'('h04);
  localparam logic [SLOT_SH-1:0] S_STAT = SLOT_SH'('h08);

  localparam logic [DATA_W-1:0] V_RELEASED = DATA_W'('h1);
  localparam logic [DATA_W-1:0] V_CORE_RST = DATA_W'('h3);
  localparam logic [DATA_W-1:0] V_SMP      = DATA_W'('h1);
  localparam logic [DATA_W-1:0] V_CLK_GATE = DATA_W'('h10F);

  logic [DATA_W-1:0] gen_q, stby_q, entry_q, rd_q;
  logic [DATA_W-1:0] rd_val;
  logic [NCORES-1:0] start_q, start_d;
  logic              unimp_hit, oob_hit, unimp_q, oob_q;

  wire                aligned   = (bus_addr[1:0] == 2'b00);
  wire                core_zone = (bus_addr >= A_CORE_LO) && (bus_addr < A_CORE_HI);
  wire [SLOT_SH-1:0]  slot      = bus_addr[SLOT_SH-1:0];
  wire [ADDR_W-1:0]   core_off  = bus_addr - A_CORE_LO;
  wire [IDX_W-1:0]    core_idx  = core_off[SLOT_SH +: IDX_W];
  wire                wr_ok     = bus_we && aligned;
  wire                kick      = wr_ok && core_zone && (slot == S_RST) && (|bus_wdata);

  always_comb begin
    rd_val    = '0;
    unimp_hit = 1'b0;
    oob_hit   = 1'b0;
    if (!aligned) begin
      oob_hit = 1'b1;
    end else if (core_zone) begin
      case (slot)
        S_RST:   rd_val = V_CORE_RST;
        S_CTRL:  rd_val = '0;
        S_STAT:  rd_val = V_SMP;
        default: oob_hit = 1'b1;
      endcase
    end else begin
      case (bus_addr)
        A_CLU_RST, A_SYS_RST:                  rd_val = V_RELEASED;
        A_CLK_GATE:                            rd_val = V_CLK_GATE;
        A_GEN:                                 rd_val = gen_q;
        A_STBY:                                rd_val = stby_q;
        A_ENTRY:                               rd_val = entry_q;
        A_DBG, A_CNT_CTL, A_CNT_LO, A_CNT_HI:  unimp_hit = 1'b1;
        default:                               oob_hit = 1'b1;
      endcase
    end
  end

  always_comb begin
    start_d = '0;
    if (kick) start_d[core_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_q   <= GEN_RST;
      stby_q  <= '0;
      entry_q <= '0;
    end else if (wr_ok) begin
      if (bus_addr == A_GEN)   gen_q   <= bus_wdata;
      if (bus_addr == A_STBY)  stby_q  <= bus_wdata;
      if (bus_addr == A_ENTRY) entry_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q    <= '0;
      start_q <= '0;
      unimp_q <= 1'b0;
      oob_q   <= 1'b0;
    end else begin
      rd_q    <= bus_re ? rd_val : '0;
      start_q <= start_d;
      unimp_q <= (bus_re || bus_we) && unimp_hit;
      oob_q   <= (bus_re || bus_we) && oob_hit;
    end
  end

  assign rd_data    = rd_q;
  assign core_start = start_q;
  assign start_addr = entry_q;
  assign start_el   = BOOT_EL;
  assign unimpl_err = unimp_q;
  assign range_err  = oob_q;

  // R6
  start_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(core_start));

  // R6
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|core_start) |-> ($past(bus_we) && ($past(bus_wdata) != '0)));

  // R6
  start_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|core_start) |-> $stable(start_addr));

  // R8
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_re) |-> (rd_data == '0));

  // R2
  sys_rst_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_re && (bus_addr == A_SYS_RST)) |-> (rd_data == V_RELEASED));

  // R4
  clk_gate_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_re && (bus_addr == A_CLK_GATE)) |-> (rd_data == V_CLK_GATE));

  // R9
  unimpl_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unimpl_err |-> $past(bus_re || bus_we));

  // R10
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(unimpl_err && range_err));

  // R10
  misaligned_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past((bus_re || bus_we) && (bus_addr[1:0] != 2'b00)) |-> range_err);

endmodule

// File: tb/sim_cpu_cluster_cfg.sv
module sim_cpu_cluster_cfg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] rd_data;
  logic [3:0]  core_start;
  logic [31:0] start_addr;
  logic [1:0]  start_el;
  logic        unimpl_err, range_err;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  cpu_cluster_cfg u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .rd_data(rd_data),
    .core_start(core_start), .start_addr(start_addr), .start_el(start_el),
    .unimpl_err(unimpl_err), .range_err(range_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = wr; bus_re = ~wr; bus_wdata = wr ? d : 32'h0;
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0; bus_wdata = '0;
  endtask

  // vector: {write, addr, data-or-expected, {unimpl, range}}
  localparam int NV = 42;
  localparam logic [44:0] VEC [NV] = '{
    {1'b0, 10'h184, 32'h0000_0020, 2'b00},  // R1
    {1'b0, 10'h1A0, 32'h0000_0000, 2'b00},  // R1
    {1'b0, 10'h1A4, 32'h0000_0000, 2'b00},  // R1
    {1'b0, 10'h000, 32'h0000_0001, 2'b00},  // R2
    {1'b1, 10'h000, 32'h0000_0000, 2'b00},  // R2
    {1'b0, 10'h000, 32'h0000_0001, 2'b00},  // R2
    {1'b0, 10'h140, 32'h0000_0001, 2'b00},  // R2
    {1'b1, 10'h140, 32'hFFFF_FFFF, 2'b00},  // R2
    {1'b0, 10'h140, 32'h0000_0001, 2'b00},  // R2
    {1'b0, 10'h040, 32'h0000_0003, 2'b00},  // R3
    {1'b0, 10'h100, 32'h0000_0003, 2'b00},  // R3
    {1'b0, 10'h0C4, 32'h0000_0000, 2'b00},  // R3
    {1'b0, 10'h048, 32'h0000_0001, 2'b00},  // R3
    {1'b0, 10'h108, 32'h0000_0001, 2'b00},  // R3
    {1'b0, 10'h144, 32'h0000_010F, 2'b00},  // R4
    {1'b1, 10'h144, 32'h0000_0000, 2'b00},  // R4
    {1'b0, 10'h144, 32'h0000_010F, 2'b00},  // R4
    {1'b1, 10'h184, 32'hA5A5_5A5A, 2'b00},  // R5
    {1'b0, 10'h184, 32'hA5A5_5A5A, 2'b00},  // R5
    {1'b1, 10'h1A0, 32'h0000_0001, 2'b00},  // R5
    {1'b0, 10'h1A0, 32'h0000_0001, 2'b00},  // R5
    {1'b1, 10'h1A4, 32'h8000_1000, 2'b00},  // R5
    {1'b0, 10'h1A4, 32'h8000_1000, 2'b00},  // R5
    {1'b1, 10'h080, 32'h0000_0000, 2'b00},  // R7
    {1'b1, 10'h104, 32'hFFFF_FFFF, 2'b00},  // R11
    {1'b0, 10'h104, 32'h0000_0000, 2'b00},  // R11
    {1'b1, 10'h088, 32'h0000_0000, 2'b00},  // R11
    {1'b0, 10'h088, 32'h0000_0001, 2'b00},  // R11
    {1'b0, 10'h1E4, 32'h0000_0000, 2'b10},  // R9
    {1'b0, 10'h280, 32'h0000_0000, 2'b10},  // R9
    {1'b0, 10'h284, 32'h0000_0000, 2'b10},  // R9
    {1'b1, 10'h288, 32'h1234_5678, 2'b10},  // R9
    {1'b0, 10'h288, 32'h0000_0000, 2'b10},  // R9
    {1'b0, 10'h3FC, 32'h0000_0000, 2'b01},  // R10
    {1'b0, 10'h04C, 32'h0000_0000, 2'b01},  // R10
    {1'b0, 10'h2A0, 32'h0000_0000, 2'b01},  // R10
    {1'b0, 10'h186, 32'h0000_0000, 2'b01},  // R10
    {1'b1, 10'h185, 32'h0000_1234, 2'b01},  // R10
    {1'b1, 10'h1A5, 32'h0000_0077, 2'b01},  // R10
    {1'b0, 10'h184, 32'hA5A5_5A5A, 2'b00},  // R10
    {1'b0, 10'h1A4, 32'h8000_1000, 2'b00},  // R10
    {1'b1, 10'h041, 32'h0000_0001, 2'b01}   // R10
  };

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 core_start in reset", {28'h0, core_start}, 32'h0);
    check("R1 flags in reset", {30'h0, unimpl_err, range_err}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rd_data after reset", rd_data, 32'h0);
    check("R1 start_addr after reset", start_addr, 32'h0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][44], VEC[i][43:34], VEC[i][33:2]);
      if (!VEC[i][44])
        check($sformatf("vec%0d rd_data @%03h", i, VEC[i][43:34]), rd_data, VEC[i][33:2]);
      check($sformatf("vec%0d flags @%03h (R9/R10)", i, VEC[i][43:34]),
            {30'h0, unimpl_err, range_err}, {30'h0, VEC[i][1:0]});
      check($sformatf("vec%0d no start (R7)", i), {28'h0, core_start}, 32'h0);
    end

    // R8: read data drops to zero the cycle after the read
    access(1'b0, 10'h144, 32'h0);
    check("R8 read valid", rd_data, 32'h0000_010F);
    @(negedge clk);
    check("R8 idle zero", rd_data, 32'h0);
    check("R9 flag one cycle", {30'h0, unimpl_err, range_err}, 32'h0);

    // R6: per-core start pulse
    for (int n = 0; n < 4; n++) begin
      access(1'b1, 10'h1A4, 32'h4000_0000 + 32'(n) * 32'h100);
      access(1'b1, 10'(10'h040 + 10'(n) * 10'h040), 32'(n + 1) << n);
      check($sformatf("R6 core_start n=%0d", n), {28'h0, core_start}, 32'(1) << n);
      check($sformatf("R6 start_addr n=%0d", n), start_addr, 32'h4000_0000 + 32'(n) * 32'h100);
      check($sformatf("R6 start_el n=%0d", n), {30'h0, start_el}, 32'd3);
      @(negedge clk);
      check($sformatf("R6 pulse width n=%0d", n), {28'h0, core_start}, 32'h0);
    end

    // R7: zero write to core 2 reset register
    access(1'b1, 10'h0C0, 32'h0);
    check("R7 zero write no start", {28'h0, core_start}, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule